// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Recency Replacement

This block caches virtual-to-physical page mappings for an address-translation path. Its storage is split into sets of ways, and each entry carries its own page size, written as the log2 of its byte count. An entry matches any address that falls inside its page, so pages of mixed sizes share one array. A single command port issues four operations: lookup (optionally refreshing recency), insert with replacement, demap of one page, and flush of everything. The response gives the hit flag, the physical address, a write-protection fault and the uncacheable attribute of the matching entry.

Each set keeps an ordered list of its ways, from most to least recently used. A command is accepted with a valid/ready handshake. The array and the order list are updated one cycle after acceptance, and the port stalls during that cycle. `WAYS` must not exceed `ENTRIES`, and both must be powers of two. When they are equal, the array is fully associative and every address uses set zero. Page walking, queuing of outstanding requests and statistics are handled elsewhere.

Top module: `xlat_buffer`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the next cycle. `rsp_valid` pulses high for one cycle, two edges after acceptance. After reset, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: The number of sets is `ENTRIES/WAYS`. The set used by any command is address bits [12 +: log2(sets)], which is the virtual address shifted right by 12 and reduced modulo the number of sets.
- R3: An entry in the indexed set hits when it is valid, its base virtual address is at most the address, and the base plus 2^size is greater than the address. A lookup that misses returns `rsp_hit`=0, `rsp_pa`=0, `rsp_fault`=0 and `rsp_uncached`=0.
- R4: When several entries hit, the one nearest the most-recently-used end of the set's order wins. Lookup (`cmd_op`=2'b00) with `cmd_touch`=1 moves the winner to most recently used. With `cmd_touch`=0 the order is left unchanged.
- R5: Insert (`cmd_op`=2'b01) with `cmd_alloc`=1 writes into the lowest-numbered free way of the set. If no way is free, it overwrites the least recently used way. The written way becomes most recently used. With `cmd_alloc`=0 the array is left unchanged.
- R6: Flush (`cmd_op`=2'b11) frees every entry. Demap (`cmd_op`=2'b10) frees only the winning matching entry, reports `rsp_hit`=1 if one was freed, and leaves the order unchanged.
- R7: The size field `ins_lg` is clamped to the range 12..`MAX_LOG`. The stored virtual and physical bases are the inputs with the low size bits cleared. The physical address is the physical base plus the virtual address masked by 2^size-1. An insert responds with this translation for the supplied fields.
- R8: A write (`cmd_write`=1) that resolves to an entry whose writable bit is 0 sets `rsp_fault`. The entry's uncacheable bit is reported on `rsp_uncached`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 00 lookup, 01 insert, 10 demap, 11 flush |
| cmd_touch | input | 1 | Lookup refreshes recency on a hit |
| cmd_write | input | 1 | Access is a write |
| cmd_alloc | input | 1 | Insert actually installs the entry |
| cmd_va | input | 32 | Virtual address |
| ins_pa | input | 32 | Physical address for insert |
| ins_lg | input | 5 | log2 of page bytes for insert |
| ins_writable | input | 1 | Page may be written |
| ins_uncached | input | 1 | Page is uncacheable |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation found, or entry freed by demap |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_uncached | output | 1 | Uncacheable attribute |

## Verification
The hardest state to reach is a full set with a recency order that differs from the order of insertion. Only then does an eviction show whether touching, non-touching lookups and demaps each left the order list correct. Directed sequences fill one set, reorder it with a touching lookup and then overflow it. Randomized traffic over a small page pool with mixed sizes keeps sets full, and it produces overlapping pages that exercise the winner priority against an independent bench model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W       = 32;
    localparam int PA_W       = 32;
    localparam int BASE_SHIFT = 12;
    localparam int LG_W       = 5;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'b00,
        OP_INSERT = 2'b01,
        OP_DEMAP  = 2'b10,
        OP_FLUSH  = 2'b11
    } xlat_op_e;

    typedef struct packed {
        logic            vld;
        logic [VA_W-1:0] va_base;
        logic [PA_W-1:0] pa_base;
        logic [LG_W-1:0] lg;
        logic            wr_ok;
        logic            uc;
    } xlat_entry_t;

    typedef struct packed {
        xlat_op_e        op;
        logic            touch;
        logic            is_wr;
        logic            alloc;
        logic [VA_W-1:0] va;
        logic [PA_W-1:0] pa;
        logic [LG_W-1:0] lg;
        logic            wr_ok;
        logic            uc;
    } xlat_cmd_t;

    function automatic logic [LG_W-1:0] clamp_lg(input logic [LG_W-1:0] lg,
                                                 input int max_lg);
        if (int'(lg) < BASE_SHIFT)  return LG_W'(BASE_SHIFT);
        else if (int'(lg) > max_lg) return LG_W'(max_lg);
        else                        return lg;
    endfunction

    function automatic logic [VA_W-1:0] va_mask(input logic [LG_W-1:0] lg);
        return (VA_W'(1) << lg) - VA_W'(1);
    endfunction

    function automatic logic [PA_W-1:0] pa_mask(input logic [LG_W-1:0] lg);
        return (PA_W'(1) << lg) - PA_W'(1);
    endfunction

endpackage

// File: rtl/xlat_range_cmp.sv
module xlat_range_cmp
    import xlat_pkg::*;
(
    input  xlat_entry_t     ent,
    input  logic [VA_W-1:0] va,
    output logic            hit
);
    logic [VA_W:0] upper;
    logic          above_base;
    logic          below_top;

    always_comb begin
        upper      = {1'b0, ent.va_base} + ((VA_W+1)'(1) << ent.lg);
        above_base = (ent.va_base <= va);
        below_top  = ({1'b0, va} < upper);
        hit        = ent.vld && above_base && below_top;
    end
endmodule

// File: rtl/xlat_recency.sv
module xlat_recency #(
    parameter int SETS = 2,
    parameter int WAYS = 4,
    localparam int IW = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] rd_set,
    output logic [IW-1:0] rd_order [WAYS],
    input  logic          upd_en,
    input  logic [SW-1:0] upd_set,
    input  logic [IW-1:0] upd_way
);
    logic [IW-1:0] ord [SETS][WAYS];
    logic [IW-1:0] row [WAYS];
    logic [IW-1:0] nxt [WAYS];
    int            pos;

    always_comb begin
        for (int p = 0; p < WAYS; p++) rd_order[p] = ord[rd_set][p];
    end

    always_comb begin
        pos = 0;
        for (int p = 0; p < WAYS; p++) begin
            row[p] = ord[upd_set][p];
            if (ord[upd_set][p] == upd_way) pos = p;
        end
        nxt[0] = upd_way;
        for (int p = 1; p < WAYS; p++) nxt[p] = (p > pos) ? row[p] : row[p-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int p = 0; p < WAYS; p++)
                    ord[s][p] <= IW'(p);
        end else if (upd_en) begin
            for (int p = 0; p < WAYS; p++) ord[upd_set][p] <= nxt[p];
        end
    end

    logic [WAYS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int p = 0; p < WAYS; p++) seen[rd_order[p]] = 1'b1;
    end

    AST_ORDER_PERM: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == WAYS); // R4
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WAYS    = 4,
    parameter int MAX_LOG = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic            cmd_touch,
    input  logic            cmd_write,
    input  logic            cmd_alloc,
    input  logic [VA_W-1:0] cmd_va,
    input  logic [PA_W-1:0] ins_pa,
    input  logic [LG_W-1:0] ins_lg,
    input  logic            ins_writable,
    input  logic            ins_uncached,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_pa,
    output logic            rsp_fault,
    output logic            rsp_uncached
);
    localparam int SETS = ENTRIES / WAYS;
    localparam int SW   = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int IW   = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int EW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // command stage
    logic      s_valid;
    xlat_cmd_t s_cmd;

    assign cmd_ready = !s_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_cmd   <= '0;
        end else if (cmd_valid && cmd_ready) begin
            s_valid     <= 1'b1;
            s_cmd.op    <= xlat_op_e'(cmd_op);
            s_cmd.touch <= cmd_touch;
            s_cmd.is_wr <= cmd_write;
            s_cmd.alloc <= cmd_alloc;
            s_cmd.va    <= cmd_va;
            s_cmd.pa    <= ins_pa;
            s_cmd.lg    <= ins_lg;
            s_cmd.wr_ok <= ins_writable;
            s_cmd.uc    <= ins_uncached;
        end else begin
            s_valid <= 1'b0;
        end
    end

    // set selection
    logic [SW-1:0] cur_set;
    generate
        if (SETS > 1) begin : g_set_idx
            assign cur_set = s_cmd.va[BASE_SHIFT +: SW];
        end else begin : g_full_assoc
            assign cur_set = '0;
        end
    endgenerate

    // storage and per-way compare
    xlat_entry_t     ents [ENTRIES];
    xlat_entry_t     way_ent [WAYS];
    logic [WAYS-1:0] way_hit;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign way_ent[w] = ents[EW'(int'(cur_set) * WAYS + w)];
            xlat_range_cmp u_cmp (
                .ent (way_ent[w]),
                .va  (s_cmd.va),
                .hit (way_hit[w])
            );
        end
    endgenerate

    // recency
    logic [IW-1:0] rd_order [WAYS];
    logic          upd_en;
    logic [IW-1:0] upd_way;

    xlat_recency #(.SETS(SETS), .WAYS(WAYS)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (cur_set),
        .rd_order (rd_order),
        .upd_en   (upd_en),
        .upd_set  (cur_set),
        .upd_way  (upd_way)
    );

    // winner by recency, free way, victim
    logic          win_found;
    logic [IW-1:0] win_way;
    logic          free_found;
    logic [IW-1:0] free_way;
    logic [IW-1:0] victim;

    always_comb begin
        win_found = 1'b0;
        win_way   = '0;
        for (int p = 0; p < WAYS; p++) begin
            if (!win_found && way_hit[rd_order[p]]) begin
                win_found = 1'b1;
                win_way   = rd_order[p];
            end
        end
        free_found = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!free_found && !way_ent[w].vld) begin
                free_found = 1'b1;
                free_way   = IW'(w);
            end
        end
        victim = free_found ? free_way : rd_order[WAYS-1];
    end

    // new entry formed from the command
    xlat_entry_t     win_ent;
    xlat_entry_t     new_ent;
    logic [LG_W-1:0] lg_c;

    always_comb begin
        win_ent         = way_ent[win_way];
        lg_c            = clamp_lg(s_cmd.lg, MAX_LOG);
        new_ent.vld     = 1'b1;
        new_ent.lg      = lg_c;
        new_ent.va_base = s_cmd.va & ~va_mask(lg_c);
        new_ent.pa_base = s_cmd.pa & ~pa_mask(lg_c);
        new_ent.wr_ok   = s_cmd.wr_ok;
        new_ent.uc      = s_cmd.uc;
    end

    assign upd_en  = s_valid && (((s_cmd.op == OP_LOOKUP) && s_cmd.touch && win_found) ||
                                 ((s_cmd.op == OP_INSERT) && s_cmd.alloc));
    assign upd_way = (s_cmd.op == OP_INSERT) ? victim : win_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else if (s_valid) begin
            case (s_cmd.op)
                OP_INSERT: if (s_cmd.alloc)
                    ents[EW'(int'(cur_set) * WAYS + int'(victim))] <= new_ent;
                OP_DEMAP: if (win_found)
                    ents[EW'(int'(cur_set) * WAYS + int'(win_way))].vld <= 1'b0;
                OP_FLUSH:
                    for (int i = 0; i < ENTRIES; i++) ents[i].vld <= 1'b0;
                default: ;
            endcase
        end
    end

    // response
    logic            n_hit, n_fault, n_uc;
    logic [PA_W-1:0] n_pa;

    always_comb begin
        n_hit   = 1'b0;
        n_pa    = '0;
        n_fault = 1'b0;
        n_uc    = 1'b0;
        if (s_valid) begin
            case (s_cmd.op)
                OP_LOOKUP: if (win_found) begin
                    n_hit   = 1'b1;
                    n_pa    = win_ent.pa_base + PA_W'(s_cmd.va & va_mask(win_ent.lg));
                    n_fault = s_cmd.is_wr && !win_ent.wr_ok;
                    n_uc    = win_ent.uc;
                end
                OP_INSERT: begin
                    n_hit   = 1'b1;
                    n_pa    = new_ent.pa_base + PA_W'(s_cmd.va & va_mask(lg_c));
                    n_fault = s_cmd.is_wr && !new_ent.wr_ok;
                    n_uc    = new_ent.uc;
                end
                OP_DEMAP: n_hit = win_found;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_pa       <= '0;
            rsp_fault    <= 1'b0;
            rsp_uncached <= 1'b0;
        end else begin
            rsp_valid    <= s_valid;
            rsp_hit      <= n_hit;
            rsp_pa       <= n_pa;
            rsp_fault    <= n_fault;
            rsp_uncached <= n_uc;
        end
    end

    // assertions
    logic [ENTRIES-1:0] vld_vec;
    always_comb for (int i = 0; i < ENTRIES; i++) vld_vec[i] = ents[i].vld;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> ##1 rsp_valid); // R1
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_fault && !rsp_uncached)); // R3
    AST_NOALLOC_KEEP: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_cmd.op == OP_INSERT && !s_cmd.alloc) |=> $stable(vld_vec)); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (s_valid && s_cmd.op == OP_FLUSH) |=> (vld_vec == '0)); // R6
    AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> rsp_hit); // R8
endmodule

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;
    localparam int ENTRIES = 8;
    localparam int WAYS    = 4;
    localparam int MAX_LOG = 21;
    localparam int SETS    = ENTRIES / WAYS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic        cmd_touch = 0, cmd_write = 0, cmd_alloc = 0;
    logic [31:0] cmd_va = '0, ins_pa = '0;
    logic [4:0]  ins_lg = '0;
    logic        ins_writable = 0, ins_uncached = 0;
    logic        rsp_valid, rsp_hit, rsp_fault, rsp_uncached;
    logic [31:0] rsp_pa;

    always #4 clk = ~clk;

    xlat_buffer #(.ENTRIES(ENTRIES), .WAYS(WAYS), .MAX_LOG(MAX_LOG)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_touch(cmd_touch), .cmd_write(cmd_write),
        .cmd_alloc(cmd_alloc), .cmd_va(cmd_va), .ins_pa(ins_pa), .ins_lg(ins_lg),
        .ins_writable(ins_writable), .ins_uncached(ins_uncached),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_uncached(rsp_uncached)
    );

    int n_chk = 0, n_fail = 0;

    // reference model
    bit     m_vld [ENTRIES];
    longint m_va  [ENTRIES];
    longint m_pa  [ENTRIES];
    int     m_lg  [ENTRIES];
    bit     m_wr  [ENTRIES];
    bit     m_uc  [ENTRIES];
    int     m_ord [SETS][WAYS];

    function automatic int lg_clamp(int lg);
        if (lg < 12) return 12;
        if (lg > MAX_LOG) return MAX_LOG;
        return lg;
    endfunction

    task automatic to_front(input int s, input int w);
        int pos = 0;
        for (int p = 0; p < WAYS; p++) if (m_ord[s][p] == w) pos = p;
        for (int p = pos; p > 0; p--) m_ord[s][p] = m_ord[s][p-1];
        m_ord[s][0] = w;
    endtask

    task automatic model(input int op, input bit touch, input bit wr, input bit alloc,
                         input longint va, input longint pa, input int lg,
                         input bit wok, input bit uc,
                         output bit e_hit, output longint e_pa,
                         output bit e_f, output bit e_uc);
        int s = int'((va >> 12) % SETS);
        int win = -1;
        e_hit = 0; e_pa = 0; e_f = 0; e_uc = 0;
        for (int p = 0; p < WAYS; p++) begin
            int i = s * WAYS + m_ord[s][p];
            if (win < 0 && m_vld[i] && m_va[i] <= va && va < m_va[i] + (64'd1 << m_lg[i]))
                win = m_ord[s][p];
        end
        case (op)
            0: if (win >= 0) begin
                int i = s * WAYS + win;
                e_hit = 1;
                e_pa  = (m_pa[i] + (va & ((64'd1 << m_lg[i]) - 1))) & 64'hFFFF_FFFF;
                e_f   = wr && !m_wr[i];
                e_uc  = m_uc[i];
                if (touch) to_front(s, win);
            end
            1: begin
                int l = lg_clamp(lg);
                longint msk = (64'd1 << l) - 1;
                longint bva = va & ~msk;
                longint bpa = pa & ~msk;
                e_hit = 1;
                e_pa  = (bpa + (va & msk)) & 64'hFFFF_FFFF;
                e_f   = wr && !wok;
                e_uc  = uc;
                if (alloc) begin
                    int vic = -1;
                    for (int w = 0; w < WAYS; w++)
                        if (vic < 0 && !m_vld[s * WAYS + w]) vic = w;
                    if (vic < 0) vic = m_ord[s][WAYS-1];
                    m_vld[s*WAYS+vic] = 1; m_va[s*WAYS+vic] = bva; m_pa[s*WAYS+vic] = bpa;
                    m_lg[s*WAYS+vic] = l; m_wr[s*WAYS+vic] = wok; m_uc[s*WAYS+vic] = uc;
                    to_front(s, vic);
                end
            end
            2: if (win >= 0) begin
                m_vld[s * WAYS + win] = 0;
                e_hit = 1;
            end
            default: for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
        endcase
    endtask

    task automatic drive(input int op, input bit touch, input bit wr, input bit alloc,
                         input longint va, input longint pa, input int lg,
                         input bit wok, input bit uc);
        cmd_op = 2'(op); cmd_touch = touch; cmd_write = wr; cmd_alloc = alloc;
        cmd_va = va[31:0]; ins_pa = pa[31:0]; ins_lg = 5'(lg);
        ins_writable = wok; ins_uncached = uc;
        cmd_valid = 1'b1;
    endtask

    task automatic compare(input string req, input bit e_hit, input longint e_pa,
                           input bit e_f, input bit e_uc);
        n_chk++;
        if (!(rsp_valid === 1'b1 && rsp_hit === e_hit && rsp_pa === e_pa[31:0] &&
              rsp_fault === e_f && rsp_uncached === e_uc)) begin
            n_fail++;
            $display("FAIL %s actual v=%0b hit=%0b pa=%h f=%0b uc=%0b expected v=1 hit=%0b pa=%h f=%0b uc=%0b",
                     req, rsp_valid, rsp_hit, rsp_pa, rsp_fault, rsp_uncached,
                     e_hit, e_pa[31:0], e_f, e_uc);
        end
    endtask

    task automatic run_cmd(input string req, input int op, input bit touch, input bit wr,
                           input bit alloc, input longint va, input longint pa,
                           input int lg, input bit wok, input bit uc);
        bit e_hit, e_f, e_uc;
        longint e_pa;
        model(op, touch, wr, alloc, va, pa, lg, wok, uc, e_hit, e_pa, e_f, e_uc);
        @(negedge clk);
        drive(op, touch, wr, alloc, va, pa, lg, wok, uc);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        compare(req, e_hit, e_pa, e_f, e_uc);
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_r;
        seed_r = $urandom(32'd4711);
        for (int i = 0; i < ENTRIES; i++) m_vld[i] = 0;
        for (int s = 0; s < SETS; s++) for (int p = 0; p < WAYS; p++) m_ord[s][p] = p;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check_bit("R1", "reset ready", cmd_ready, 1'b1);
        check_bit("R1", "reset rsp_valid", rsp_valid, 1'b0);

        // R3 empty array misses
        run_cmd("R3", 0, 1, 0, 0, 32'h5000, 0, 12, 0, 0);
        // R7 R8 insert read-only uncacheable 4 KiB page, then write fault
        run_cmd("R7", 1, 0, 0, 1, 32'h3123, 32'h8000_0777, 12, 0, 1);
        run_cmd("R8", 0, 1, 1, 0, 32'h3FFF, 0, 0, 0, 0);
        // R3 16 KiB page boundaries and R2 set selection
        run_cmd("R7", 1, 0, 1, 1, 32'h1_0000, 32'h0024_6000, 14, 1, 0);
        run_cmd("R3", 0, 1, 1, 0, 32'h1_2ABC, 0, 0, 0, 0);
        run_cmd("R3", 0, 1, 0, 0, 32'h1_4000, 0, 0, 0, 0);
        run_cmd("R2", 0, 1, 0, 0, 32'h1_3000, 0, 0, 0, 0);
        // R7 size clamp high and low
        run_cmd("R7", 1, 0, 0, 1, 32'h0060_0000, 32'h1230_0000, 30, 1, 0);
        run_cmd("R7", 0, 1, 0, 0, 32'h007F_E010, 0, 0, 0, 0);
        run_cmd("R7", 0, 1, 0, 0, 32'h0080_0000, 0, 0, 0, 0);
        run_cmd("R7", 1, 0, 0, 1, 32'h0003_5ABC, 32'h0777_7FFF, 3, 1, 1);
        // R5 no-allocate insert leaves array unchanged
        run_cmd("R5", 1, 0, 0, 0, 32'h0009_1000, 32'h4444_4000, 12, 1, 0);
        run_cmd("R5", 0, 1, 0, 0, 32'h0009_1000, 0, 0, 0, 0);
        // R6 flush, then R5 R4 fill and reorder set 0
        run_cmd("R6", 3, 0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd("R6", 0, 1, 0, 0, 32'h3123, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++)
            run_cmd("R5", 1, 0, 0, 1, longint'(k) * 32'h2000, 32'hA000_0000 + k * 32'h1000, 12, 1, 0);
        run_cmd("R4", 0, 1, 0, 0, 32'h0000_0010, 0, 0, 0, 0);
        run_cmd("R4", 0, 0, 0, 0, 32'h0000_2010, 0, 0, 0, 0);
        run_cmd("R5", 1, 0, 0, 1, 32'h8000, 32'hB000_0000, 12, 1, 0);
        run_cmd("R5", 0, 1, 0, 0, 32'h2000, 0, 0, 0, 0);
        run_cmd("R5", 0, 1, 0, 0, 32'h0000, 0, 0, 0, 0);
        // R4 R6 overlapping pages: most recent wins, demap frees only it
        run_cmd("R6", 3, 0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd("R4", 1, 0, 0, 1, 32'h0000, 32'h1111_1000, 12, 1, 0);
        run_cmd("R4", 1, 0, 0, 1, 32'h0000, 32'h2222_0000, 14, 1, 1);
        run_cmd("R4", 0, 0, 0, 0, 32'h0044, 0, 0, 0, 0);
        run_cmd("R6", 2, 0, 0, 0, 32'h0044, 0, 0, 0, 0);
        run_cmd("R6", 0, 0, 0, 0, 32'h0044, 0, 0, 0, 0);
        run_cmd("R6", 2, 0, 0, 0, 32'h0044, 0, 0, 0, 0);
        run_cmd("R6", 2, 0, 0, 0, 32'h0044, 0, 0, 0, 0);

        // R1 stall: valid held over the busy cycle gives a single response
        begin
            bit e_hit, e_f, e_uc;
            longint e_pa;
            model(1, 0, 0, 1, 32'h6000, 32'h3300_0000, 12, 1, 0, e_hit, e_pa, e_f, e_uc);
            @(negedge clk);
            drive(1, 0, 0, 1, 32'h6000, 32'h3300_0000, 12, 1, 0);
            @(negedge clk);
            check_bit("R1", "ready while busy", cmd_ready, 1'b0);
            @(negedge clk);
            cmd_valid = 1'b0;
            compare("R1", e_hit, e_pa, e_f, e_uc);
            @(negedge clk);
            check_bit("R1", "single response", rsp_valid, 1'b0);
        end

        // randomized traffic over a small page pool
        for (int n = 0; n < 600; n++) begin
            int r = int'($urandom % 100);
            int op = (r < 45) ? 0 : (r < 82) ? 1 : (r < 97) ? 2 : 3;
            longint va = (longint'($urandom % 14) << 12) | longint'($urandom % 4096);
            int lg = (($urandom % 10) == 0) ? int'($urandom % 32) : 12 + int'($urandom % 3);
            run_cmd(op == 0 ? "R4" : op == 1 ? "R5" : "R6", op, 1'($urandom), 1'($urandom),
                    ($urandom % 8) != 0, va, longint'($urandom), lg,
                    1'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule